// File: doc/BRIEF.md
# Counter Array Interrupt Aggregator

This block holds the 16-bit free-running timebase of a programmable counter array together with the tree that turns its events into one interrupt request. The count advances by one on every cycle where the count-enable pin is high. Two overflow events come from the count:

- The main overflow fires when the full count wraps.
- The intermediate overflow fires when the low 8, 9, 10 or 11 bits of the count wrap. A 2-bit width field chooses which.

Six capture/compare channels outside the block report their events as single-cycle pulses.

Each of the eight events latches into a sticky flag, whether or not its interrupt is enabled. Software uses a register-style write port to set the per-flag enables, the block enable and the width select, and to clear flags. Clearing a flag takes a write of zero to its bit. The request output is the OR of every enabled flag, gated by the block enable and by the processor's global enable pin. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake. Writes take effect on the clock edge where `wr_en` is high.

Top module: `ctr_irq_agg`

## Requirements
- R1: After reset the count, all eight flags, all enables, the block enable and the width select are zero, and `irq` is low.
- R2: The count rises by one on each rising clock edge where `cnt_en` is high, keeps its value when `cnt_en` is low, and wraps from 0xFFFF to 0x0000.
- R3: Flag bit 0 (main overflow) sets on the edge where the count goes from 0xFFFF to 0x0000.
- R4: Flag bit 1 (intermediate overflow) sets on the edge where the low N bits of the count go from all ones to all zeros, with N = 8 + sel. Here sel is bits [1:0] of the word written at address 2 (0→8, 1→9, 2→10, 3→11). The flag stays clear at the wrap points of the widths that are not selected.
- R5: Flag bits 2..7 set on the edge after `chan_evt[0]`..`chan_evt[5]` is high, respectively.
- R6: A flag sets on its event whatever the state of its enable, the block enable and `glb_en`. With those enables low, `irq` stays low.
- R7: A write to address 1 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. A set flag otherwise stays set.
- R8: When a flag's event and a clear of that flag fall on the same edge, the flag ends up set.
- R9: The word written at address 0 holds the per-flag enables in bits [7:0] (bit k enables flag bit k) and the block enable in bit 8. `irq` = `glb_en` AND block enable AND OR over k of (flag k AND enable k).
- R10: `irq` stays high as long as any enabled flag stays set and both global enables stay high. It falls in the cycle after the last enabled flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable, one increment per high cycle |
| chan_evt | input | 6 | Per-channel event pulses |
| glb_en | input | 1 | Processor-level global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 enables, 1 flag clear, 2 width select |
| wr_data | input | 9 | Write data |
| count | output | 16 | Current count value |
| flags | output | 8 | Sticky flags: bit 0 main, bit 1 intermediate, bits 2..7 channels 0..5 |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `wr_en` and `wr_addr` are never unknown once reset is released. The hold-of-request property assumes that `irq` can only fall through a register write or a drop of `glb_en`. The bench drives all inputs on the falling edge, so every write is a clean one-cycle strobe. It raises channel pulses and clears only where a scenario calls for them, and it changes the width select only while the count is below the next wrap point it is about to check.

// File: rtl/ctr_irq_pkg.sv
package ctr_irq_pkg;
  // register map of the write port
  typedef enum logic [1:0] {
    REG_ENA  = 2'd0,
    REG_FLAG = 2'd1,
    REG_WSEL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // flag vector layout
  localparam int FLG_MAIN = 0;
  localparam int FLG_MID  = 1;
  localparam int FLG_CH0  = 2;
endpackage

// File: rtl/ctr_tick.sv
module ctr_tick #(
  parameter int CNT_W    = 16,
  parameter int MID_BASE = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] wsel,
  output logic [CNT_W-1:0] count,
  output logic             main_wrap,
  output logic             mid_wrap
);
  localparam int MAX_MID = MID_BASE + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] mid_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cnt_en) count <= count + 1'b1;
  end

  // all-ones mask of the selected low-order width
  always_comb begin
    mid_mask = (CNT_W'(1) << (MID_BASE + int'(wsel))) - CNT_W'(1);
  end

  assign main_wrap = cnt_en && (count == {CNT_W{1'b1}});
  assign mid_wrap  = cnt_en && ((count & mid_mask) == mid_mask);

  initial begin
    if (MAX_MID >= CNT_W) $error("intermediate width must stay below counter width");
  end

  // R2: one step per enabled cycle, including the wrap
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> count == $past(count) + 1'b1);

  // R2: no movement without enable
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));
endmodule

// File: rtl/ctr_flag_bank.sv
module ctr_flag_bank #(
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[k] <= 1'b0;
      else if (set_i[k])   flags_o[k] <= 1'b1;
      else if (clr_i[k])   flags_o[k] <= 1'b0;
    end

    // R8: an event always leaves the flag set, even with a clear beside it
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags_o[k]);

    // R7: a set flag only falls through an explicit clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[k] && !clr_i[k]) |=> flags_o[k]);
  end
endmodule

// File: rtl/ctr_irq_gate.sv
module ctr_irq_gate #(
  parameter int NFLAG = 8
) (
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] en_i,
  input  logic             blk_en_i,
  input  logic             glb_en_i,
  output logic             irq_o
);
  logic [NFLAG-1:0] armed;

  for (genvar k = 0; k < NFLAG; k++) begin : g_arm
    assign armed[k] = flags_i[k] & en_i[k];
  end

  assign irq_o = glb_en_i & blk_en_i & (|armed);
endmodule

// File: rtl/ctr_irq_agg.sv
module ctr_irq_agg
  import ctr_irq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int N_CH     = 6,
  parameter int MID_BASE = 8,
  parameter int SEL_W    = 2,
  parameter int REG_W    = N_CH + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [N_CH-1:0]    chan_evt,
  input  logic               glb_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count,
  output logic [N_CH+1:0]    flags,
  output logic               irq
);
  localparam int NFLAG  = N_CH + 2;
  localparam int BLK_EN = NFLAG;

  logic [NFLAG-1:0] en_q;
  logic             blk_q;
  logic [SEL_W-1:0] wsel_q;
  logic             main_wrap;
  logic             mid_wrap;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic             wr_ena;
  logic             wr_flg;
  logic             wr_sel;
  logic             unused_wdata;

  initial begin
    if (REG_W < NFLAG + 1) $error("write port too narrow for enable word");
  end

  assign wr_ena = wr_en && (reg_sel_e'(wr_addr) == REG_ENA);
  assign wr_flg = wr_en && (reg_sel_e'(wr_addr) == REG_FLAG);
  assign wr_sel = wr_en && (reg_sel_e'(wr_addr) == REG_WSEL);
  assign unused_wdata = ^wr_data;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      blk_q  <= 1'b0;
      wsel_q <= '0;
    end else begin
      if (wr_ena) begin
        en_q  <= wr_data[NFLAG-1:0];
        blk_q <= wr_data[BLK_EN];
      end
      if (wr_sel) wsel_q <= wr_data[SEL_W-1:0];
    end
  end

  ctr_tick #(
    .CNT_W    (CNT_W),
    .MID_BASE (MID_BASE),
    .SEL_W    (SEL_W)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .wsel      (wsel_q),
    .count     (count),
    .main_wrap (main_wrap),
    .mid_wrap  (mid_wrap)
  );

  always_comb begin
    set_v                        = '0;
    set_v[FLG_MAIN]              = main_wrap;
    set_v[FLG_MID]               = mid_wrap;
    set_v[FLG_CH0 +: N_CH]       = chan_evt;
    clr_v = wr_flg ? ~wr_data[NFLAG-1:0] : '0;
  end

  ctr_flag_bank #(.NFLAG(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .flags_o (flags)
  );

  ctr_irq_gate #(.NFLAG(NFLAG)) u_gate (
    .flags_i  (flags),
    .en_i     (en_q),
    .blk_en_i (blk_q),
    .glb_en_i (glb_en),
    .irq_o    (irq)
  );

  // R3: full wrap of the count raises the main flag
  a_r3_main_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && count == {CNT_W{1'b1}}) |=> (flags[FLG_MAIN] && count == '0));

  // R10: without writes and with the global gate held, the request stays up
  a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en && glb_en) |=> (irq || !glb_en));

  // R9: no request without both global enables
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (glb_en && blk_q && (|flags)));
endmodule

// File: tb/test_ctr_irq_agg.sv
module test_ctr_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [5:0]  chan_evt = '0;
  logic        glb_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic [15:0] count;
  logic [7:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctr_irq_agg i_ctr_irq_agg (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .chan_evt(chan_evt),
    .glb_en(glb_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic adv(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
    exp_cnt = (exp_cnt + n) % 65536;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    chan_evt = ev;
    @(negedge clk);
    chan_evt = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_count;
    adv(10);
    chk("R2 count after 10", count, exp_cnt);
    repeat (5) @(negedge clk);
    chk("R2 count holds", count, exp_cnt);
  endtask

  task automatic t_mid(input int sel, input int target);
    wr(2'd2, 9'(sel));
    wr(2'd1, 9'd0);
    adv(target - 1 - exp_cnt);
    chk("R4 no early intermediate flag", flags[1], 0);
    adv(1);
    chk("R4 count at wrap", count, target % 65536);
    chk("R4 intermediate flag set", flags[1], 1);
  endtask

  task automatic t_main;
    wr(2'd1, 9'd0);
    adv(65535 - exp_cnt);
    chk("R3 no early main flag", flags[0], 0);
    adv(1);
    chk("R2 wrap to zero", count, 0);
    chk("R3 main flag set", flags[0], 1);
  endtask

  task automatic t_chan;
    wr(2'd1, 9'd0);
    for (int k = 0; k < 6; k++) begin
      pulse(6'(1 << k));
      chk("R5 channel flag", flags[2+k], 1);
    end
    glb_en = 1'b1;
    @(negedge clk);
    chk("R6 flags latch with enables low", flags, 8'hFC);
    chk("R6 irq low with enables low", irq, 0);
    glb_en = 1'b0;
  endtask

  task automatic t_clear;
    wr(2'd1, 9'h1FB);
    chk("R7 only bit 2 cleared", flags, 8'hF8);
    repeat (3) @(negedge clk);
    chk("R7 flags stay set", flags, 8'hF8);
    @(negedge clk);
    chan_evt = 6'b000001;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 9'h1FB;
    @(negedge clk);
    chan_evt = '0; wr_en = 1'b0;
    chk("R8 set beats clear", flags[2], 1);
  endtask

  task automatic t_irq;
    wr(2'd1, 9'd0);
    pulse(6'b000011);
    wr(2'd0, 9'h108);
    chk("R9 global enable low", irq, 0);
    glb_en = 1'b1;
    @(negedge clk);
    chk("R9 both enables high", irq, 1);
    repeat (4) @(negedge clk);
    chk("R10 irq held", irq, 1);
    wr(2'd0, 9'h008);
    chk("R9 block enable low", irq, 0);
    wr(2'd0, 9'h104);
    chk("R10 irq from flag 2", irq, 1);
    wr(2'd1, 9'h1FB);
    chk("R10 irq drops after clear", irq, 0);
    chk("R10 other flag kept", flags[3], 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_mid(0, 256);
    t_mid(1, 512);
    t_mid(2, 1024);
    t_mid(3, 2048);
    t_main();
    chk("R4 11-bit wrap at full wrap", flags[1], 1);
    t_chan();
    t_clear();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule